// File: doc/BRIEF.md
# Video Memory Access Port with Address Remapping

This block is the CPU-side access port to a 64 KiB video memory that is organised as 32K sixteen-bit words. The host programs a 15-bit word address as two bytes and sets a control byte. The control byte picks one of four address remaps, the auto-increment step, and which byte of the word advances the address. Each data access goes to the memory at the remapped byte address. The low byte of a word sits at the even byte address and the high byte at the odd one.

Reads are served from a two-byte prefetch latch, so the host gets its data in the same cycle with no wait. Writing either address byte refills the latch from the new address. Reading the selected data byte refills the latch from the current address and then advances the address. The memory is a synchronous byte-wide RAM with one cycle of read latency. The block absorbs this latency with a small sequencer and reports `busy` while it works.

The sequencer has five named states. IDLE waits for host accesses. STORE drives one memory write. FETCH_LO issues the even-byte read. FETCH_HI captures the low byte and issues the odd-byte read. FETCH_END captures the high byte. The transitions are as follows. IDLE goes to STORE on a data write, and to FETCH_LO on an address write or on a read of the selected data byte. STORE returns to IDLE. FETCH_LO goes to FETCH_HI, which goes to FETCH_END, which returns to IDLE. A pending address advance is applied as STORE or FETCH_END is left.

Top module: `vram_port`

## Requirements
- R1: After reset the word address, control fields and prefetch latch are zero, `busy`, `mem_re` and `mem_we` are low, and both data ports read 0.
- R2: A host write with `host_sel`=1 loads word address bits 7:0. A write with `host_sel`=2 loads bits 14:8 from `host_wdata[6:0]`, and `host_wdata[7]` is discarded.
- R3: Control bits 3:2 choose the remap of word address a. Mode 0 gives byte address a<<1. Modes 1, 2 and 3 rotate the low field of F=8, 9 or 10 bits. The byte address is then {a[14:F], a[F-4:0], a[F-1:F-3], 0}, the same as (a<<1 & 0xfe00)|(a<<4 & 0x01f0)|(a>>4 & 0x000e) for mode 1.
- R4: Control bits 1:0 set the step: code 0 gives 1, code 1 gives 32, codes 2 and 3 give 128. The address wraps modulo 2^15.
- R5: Control bit 7 picks the trigger byte: 0 for the low data port (`host_sel`=3), 1 for the high data port (`host_sel`=4). Only an access to the trigger byte advances the address, and only a read of it prefetches.
- R6: An address write starts a prefetch. In the next cycle `mem_re` is high at the remapped even address. In the cycle after, `mem_re` is high at that address plus one. The low and high bytes fill latch bits 7:0 and 15:8, and `busy` stays high for three cycles.
- R7: `host_rdata` shows latch bits 7:0 for `host_sel`=3, latch bits 15:8 for `host_sel`=4, and 0 for any other select. A read of the trigger byte prefetches from the current address, then advances the address.
- R8: A data write drives `mem_we` for one cycle in the following cycle. The address is the remapped address for `host_sel`=3, or that address with bit 0 set for `host_sel`=4. `mem_wdata` is the written byte, and the latch is left unchanged.
- R9: Host writes and reads made while `busy` is high are ignored. They change no control field, no address and no memory byte.
- R10: `mem_re` and `mem_we` are never high together. Read data is taken from `mem_rdata` one cycle after the matching `mem_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 3 | 0 control, 1 address low, 2 address high, 3 data low, 4 data high |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Selected prefetch latch byte |
| busy | output | 1 | Sequencer is not idle |
| mem_addr | output | 16 | Memory byte address |
| mem_re | output | 1 | Memory read enable |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, one cycle after `mem_re` |

## Verification
The properties assume that the host never raises `host_wr` and `host_rd` in the same cycle. They also assume that `mem_rdata` comes from a RAM that answers exactly one cycle after `mem_re`. The stimulus waits for `busy` to fall before each new access and never asserts both strobes together. Accesses made while busy occur only in one directed sequence, whose effect is then observed through the memory port. The RAM model answers with a fixed one-cycle delay. Unwritten bytes return a value derived from their address, so a wrong remap shows up in the prefetched data.

// File: rtl/vrp_pkg.sv
package vrp_pkg;
    localparam int WORD_W = 15;
    localparam int BYTE_W = WORD_W + 1;
    localparam int DATA_W = 8;
    localparam int SEL_W  = 3;
    localparam int MODE_N = 4;

    localparam logic [SEL_W-1:0] SEL_CTRL    = 3'd0;
    localparam logic [SEL_W-1:0] SEL_ADDR_LO = 3'd1;
    localparam logic [SEL_W-1:0] SEL_ADDR_HI = 3'd2;
    localparam logic [SEL_W-1:0] SEL_DATA_LO = 3'd3;
    localparam logic [SEL_W-1:0] SEL_DATA_HI = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STORE,
        ST_FETCH_LO,
        ST_FETCH_HI,
        ST_FETCH_END
    } seq_state_t;
endpackage

// File: rtl/vrp_remap.sv
module vrp_remap
    import vrp_pkg::*;
(
    input  logic [1:0]        mode,
    input  logic [WORD_W-1:0] word,
    output logic [BYTE_W-1:0] byte_addr
);
    logic [BYTE_W-1:0] cand [MODE_N];

    // mode 0: straight word-to-byte scaling
    assign cand[0] = {word, 1'b0};

    // modes 1..3: rotate the low field of 7+k bits left by three
    for (genvar k = 1; k < MODE_N; k++) begin : g_rot
        localparam int F = 7 + k;
        assign cand[k] = {word[WORD_W-1:F], word[F-4:0], word[F-1:F-3], 1'b0};
    end

    assign byte_addr = cand[mode];
endmodule

// File: rtl/vrp_addr.sv
module vrp_addr
    import vrp_pkg::*;
#(
    parameter int STEP_MID = 32,
    parameter int STEP_BIG = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic              advance,
    output logic [WORD_W-1:0] word_addr,
    output logic              inc_on_high,
    output logic [1:0]        remap_mode
);
    logic [1:0]        step_code;
    logic [WORD_W-1:0] step_val;

    always_comb begin
        unique case (step_code)
            2'd0:    step_val = WORD_W'(1);
            2'd1:    step_val = WORD_W'(STEP_MID);
            default: step_val = WORD_W'(STEP_BIG);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_on_high <= 1'b0;
            remap_mode  <= 2'd0;
            step_code   <= 2'd0;
        end else if (wr_ctrl) begin
            inc_on_high <= wdata[7];
            remap_mode  <= wdata[3:2];
            step_code   <= wdata[1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_addr <= '0;
        end else if (wr_lo) begin
            word_addr[DATA_W-1:0] <= wdata;
        end else if (wr_hi) begin
            word_addr[WORD_W-1:DATA_W] <= wdata[WORD_W-DATA_W-1:0];
        end else if (advance) begin
            word_addr <= word_addr + step_val;
        end
    end
endmodule

// File: rtl/vrp_seq.sv
module vrp_seq
    import vrp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_store,
    input  logic                start_fetch,
    input  logic                inc_req,
    input  logic                store_high,
    input  logic [DATA_W-1:0]   store_data,
    input  logic [BYTE_W-1:0]   byte_base,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                busy,
    output logic [2*DATA_W-1:0] latch,
    output logic                advance,
    output logic [BYTE_W-1:0]   mem_addr,
    output logic                mem_re,
    output logic                mem_we,
    output logic [DATA_W-1:0]   mem_wdata
);
    seq_state_t        state_q, state_d;
    logic              pend_inc;
    logic              wr_high;
    logic [DATA_W-1:0] wr_byte;

    // transition logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_store)      state_d = ST_STORE;
                else if (start_fetch) state_d = ST_FETCH_LO;
            end
            ST_STORE:     state_d = ST_IDLE;
            ST_FETCH_LO:  state_d = ST_FETCH_HI;
            ST_FETCH_HI:  state_d = ST_FETCH_END;
            ST_FETCH_END: state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request capture and latch fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_inc <= 1'b0;
            wr_high  <= 1'b0;
            wr_byte  <= '0;
            latch    <= '0;
        end else begin
            if (state_q == ST_IDLE && (start_store || start_fetch)) begin
                pend_inc <= inc_req;
                wr_high  <= store_high;
                wr_byte  <= store_data;
            end
            if (state_q == ST_FETCH_HI)  latch[DATA_W-1:0]        <= mem_rdata;
            if (state_q == ST_FETCH_END) latch[2*DATA_W-1:DATA_W] <= mem_rdata;
        end
    end

    // outputs
    always_comb begin
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = byte_base;
        mem_wdata = wr_byte;
        advance   = 1'b0;
        busy      = (state_q != ST_IDLE);
        unique case (state_q)
            ST_STORE: begin
                mem_we   = 1'b1;
                mem_addr = byte_base | {{(BYTE_W-1){1'b0}}, wr_high};
                advance  = pend_inc;
            end
            ST_FETCH_LO: mem_re = 1'b1;
            ST_FETCH_HI: begin
                mem_re   = 1'b1;
                mem_addr = byte_base | {{(BYTE_W-1){1'b0}}, 1'b1};
            end
            ST_FETCH_END: advance = pend_inc;
            default: ;
        endcase
    end
endmodule

// File: rtl/vram_port.sv
module vram_port
    import vrp_pkg::*;
#(
    parameter int STEP_MID = 32,
    parameter int STEP_BIG = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [SEL_W-1:0]  host_sel,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              busy,
    output logic [BYTE_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic                wr_ok, rd_ok;
    logic                sel_lo, sel_hi, trig;
    logic                inc_on_high, advance;
    logic [1:0]          remap_mode;
    logic [WORD_W-1:0]   word_addr;
    logic [BYTE_W-1:0]   byte_base;
    logic [2*DATA_W-1:0] latch;

    assign wr_ok  = host_wr && !busy;
    assign rd_ok  = host_rd && !busy && !host_wr;
    assign sel_lo = (host_sel == SEL_DATA_LO);
    assign sel_hi = (host_sel == SEL_DATA_HI);
    assign trig   = inc_on_high ? sel_hi : sel_lo;

    vrp_addr #(.STEP_MID(STEP_MID), .STEP_BIG(STEP_BIG)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ctrl     (wr_ok && host_sel == SEL_CTRL),
        .wr_lo       (wr_ok && host_sel == SEL_ADDR_LO),
        .wr_hi       (wr_ok && host_sel == SEL_ADDR_HI),
        .wdata       (host_wdata),
        .advance     (advance),
        .word_addr   (word_addr),
        .inc_on_high (inc_on_high),
        .remap_mode  (remap_mode)
    );

    vrp_remap u_remap (
        .mode      (remap_mode),
        .word      (word_addr),
        .byte_addr (byte_base)
    );

    vrp_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_store (wr_ok && (sel_lo || sel_hi)),
        .start_fetch ((wr_ok && (host_sel == SEL_ADDR_LO || host_sel == SEL_ADDR_HI))
                      || (rd_ok && trig)),
        .inc_req     (trig),
        .store_high  (sel_hi),
        .store_data  (host_wdata),
        .byte_base   (byte_base),
        .mem_rdata   (mem_rdata),
        .busy        (busy),
        .latch       (latch),
        .advance     (advance),
        .mem_addr    (mem_addr),
        .mem_re      (mem_re),
        .mem_we      (mem_we),
        .mem_wdata   (mem_wdata)
    );

    always_comb begin
        if (sel_hi)      host_rdata = latch[2*DATA_W-1:DATA_W];
        else if (sel_lo) host_rdata = latch[DATA_W-1:0];
        else             host_rdata = '0;
    end
endmodule

// File: rtl/vram_port_chk.sv
module vram_port_chk
    import vrp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic [SEL_W-1:0]  host_sel,
    input logic [DATA_W-1:0] host_wdata,
    input logic [DATA_W-1:0] host_rdata,
    input logic              busy,
    input logic [BYTE_W-1:0] mem_addr,
    input logic              mem_re,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_wdata
);
    // R10
    mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R6
    fetch_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !busy && (host_sel == SEL_ADDR_LO || host_sel == SEL_ADDR_HI))
        |=> (mem_re && !mem_addr[0] && busy));

    // R6
    fetch_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && !mem_addr[0]) |=> (mem_re && mem_addr == ($past(mem_addr) | 16'h0001)));

    // R8
    store_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !busy && host_sel == SEL_DATA_LO)
        |=> (mem_we && !mem_addr[0] && mem_wdata == $past(host_wdata)));

    // R8
    store_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !busy && host_sel == SEL_DATA_HI)
        |=> (mem_we && mem_addr[0] && mem_wdata == $past(host_wdata)));

    // R9
    ignored_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_wr) |=> !mem_we);

    // R7
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel == SEL_CTRL || host_sel == SEL_ADDR_LO || host_sel == SEL_ADDR_HI)
        |-> host_rdata == '0);
endmodule

bind vram_port vram_port_chk u_chk (.*);

// File: tb/vram_port_test.sv
`timescale 1ns/1ps
module vram_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [2:0]  host_sel = 3'd0;
    logic [7:0]  host_wdata = 8'd0;
    logic [7:0]  host_rdata;
    logic        busy;
    logic [15:0] mem_addr;
    logic        mem_re, mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'd0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0]  ram [int];
    logic [7:0]  shadow [int];
    logic [14:0] r_addr = '0;
    logic        r_inc_hi = 1'b0;
    logic [1:0]  r_mode = '0;
    logic [1:0]  r_step = '0;
    logic [15:0] r_latch = '0;

    vram_port uut (.*);

    always #2 clk = ~clk;

    function automatic logic [7:0] seed_byte(input int a);
        return 8'(a ^ (a >> 8) ^ 8'h5a);
    endfunction

    function automatic logic [7:0] ram_get(input int a);
        return ram.exists(a) ? ram[a] : seed_byte(a);
    endfunction

    function automatic logic [7:0] sh_get(input int a);
        return shadow.exists(a) ? shadow[a] : seed_byte(a);
    endfunction

    always @(posedge clk) begin
        if (mem_we) ram[int'(mem_addr)] = mem_wdata;
        if (mem_re) mem_rdata <= ram_get(int'(mem_addr));
    end

    function automatic logic [15:0] ref_map(input logic [14:0] a, input logic [1:0] m);
        logic [15:0] x;
        x = {1'b0, a};
        case (m)
            2'd0:    return x << 1;
            2'd1:    return ((x << 1) & 16'hfe00) | ((x << 4) & 16'h01f0) | ((x >> 4) & 16'h000e);
            2'd2:    return ((x << 1) & 16'hfc00) | ((x << 4) & 16'h03f0) | ((x >> 5) & 16'h000e);
            default: return ((x << 1) & 16'hf800) | ((x << 4) & 16'h07f0) | ((x >> 6) & 16'h000e);
        endcase
    endfunction

    function automatic logic [14:0] ref_step(input logic [1:0] c);
        return (c == 2'd0) ? 15'd1 : (c == 2'd1) ? 15'd32 : 15'd128;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic fetch_ref();
        logic [15:0] b;
        b = ref_map(r_addr, r_mode);
        r_latch = {sh_get(int'(b) + 1), sh_get(int'(b))};
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic access(input logic wr, input logic [2:0] sel, input logic [7:0] d, input string tag);
        logic [15:0] b;
        logic        trig, dsel;
        b    = ref_map(r_addr, r_mode);
        dsel = (sel == 3'd3 || sel == 3'd4);
        trig = (sel == (r_inc_hi ? 3'd4 : 3'd3));
        @(negedge clk);
        host_wr = wr; host_rd = !wr; host_sel = sel; host_wdata = d;
        #1;
        if (!wr) check(tag, host_rdata,
                       sel == 3'd4 ? r_latch[15:8] : sel == 3'd3 ? r_latch[7:0] : 8'd0);
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        if (wr && dsel) begin
            b = b | {15'd0, sel == 3'd4};
            check(tag, {mem_we, mem_re, mem_addr, mem_wdata}, {1'b1, 1'b0, b, d});
            shadow[int'(b)] = d;
            if (trig) r_addr = r_addr + ref_step(r_step);
        end else if (wr && sel == 3'd0) begin
            r_inc_hi = d[7]; r_mode = d[3:2]; r_step = d[1:0];
        end else if (wr && (sel == 3'd1 || sel == 3'd2)) begin
            if (sel == 3'd1) r_addr[7:0] = d;
            else             r_addr[14:8] = d[6:0];
            b = ref_map(r_addr, r_mode);
            check(tag, {busy, mem_re, mem_we, mem_addr}, {1'b1, 1'b1, 1'b0, b});
            fetch_ref();
        end else if (!wr && dsel && trig) begin
            fetch_ref();
            r_addr = r_addr + ref_step(r_step);
        end else if (!wr) begin
            check(tag, {busy, mem_re}, 2'b00);
        end
        wait_idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] b;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        host_sel = 3'd3; #1;
        check("R1", {host_rdata, busy, mem_re, mem_we}, 11'd0);
        host_sel = 3'd4; #1;
        check("R1", host_rdata, 8'd0);

        // R2: high byte drops bit 7
        access(1, 3'd0, 8'h00, "R2");
        access(1, 3'd2, 8'hff, "R2");
        access(1, 3'd1, 8'h00, "R2");
        access(1, 3'd3, 8'h11, "R2");

        // R3: each remap mode
        for (int m = 0; m < 4; m++) begin
            access(1, 3'd0, 8'(m << 2), "R3");
            access(1, 3'd1, 8'ha5, "R3");
            access(1, 3'd2, 8'h5a, "R3");
            access(1, 3'd3, 8'(m), "R3");
            access(1, 3'd4, 8'(m + 8), "R3");
        end

        // R4: step codes including wrap
        for (int s = 0; s < 4; s++) begin
            access(1, 3'd0, 8'(s), "R4");
            access(1, 3'd2, 8'h7f, "R4");
            access(1, 3'd1, 8'hf0, "R4");
            access(1, 3'd3, 8'h21, "R4");
            access(1, 3'd3, 8'h22, "R4");
            access(1, 3'd3, 8'h23, "R4");
        end

        // R5: trigger on high byte
        access(1, 3'd0, 8'h80, "R5");
        access(1, 3'd2, 8'h00, "R5");
        access(1, 3'd1, 8'h40, "R5");
        access(1, 3'd3, 8'h31, "R5");
        access(1, 3'd3, 8'h32, "R5");
        access(1, 3'd4, 8'h33, "R5");
        access(1, 3'd3, 8'h34, "R5");
        access(0, 3'd3, 8'h00, "R5");
        access(0, 3'd4, 8'h00, "R5");
        access(0, 3'd4, 8'h00, "R5");

        // R6 / R7: reads with prefetch, step 32, trigger on low byte
        access(1, 3'd0, 8'h01, "R7");
        access(1, 3'd1, 8'h08, "R6");
        access(0, 3'd4, 8'h00, "R7");
        for (int i = 0; i < 4; i++) access(0, 3'd3, 8'h00, "R7");
        access(0, 3'd0, 8'h00, "R7");

        // R9 / R10: accesses during a prefetch are ignored
        access(1, 3'd0, 8'h00, "R9");
        access(1, 3'd2, 8'h00, "R9");
        @(negedge clk);
        host_wr = 1'b1; host_sel = 3'd1; host_wdata = 8'h10;
        r_addr[7:0] = 8'h10;
        b = ref_map(r_addr, r_mode);
        @(negedge clk);
        host_sel = 3'd0; host_wdata = 8'hff;
        check("R10", {mem_re, mem_we, mem_addr}, {1'b1, 1'b0, b});
        @(negedge clk);
        host_sel = 3'd3; host_wdata = 8'haa;
        check("R10", {mem_re, mem_we, mem_addr}, {1'b1, 1'b0, b | 16'h1});
        @(negedge clk);
        host_wr = 1'b0;
        check("R9", {busy, mem_we}, 2'b10);
        @(negedge clk);
        check("R9", {busy, mem_we}, 2'b00);
        fetch_ref();
        access(1, 3'd3, 8'h3c, "R9");
        access(1, 3'd1, 8'h10, "R9");
        access(0, 3'd3, 8'h00, "R9");

        // random mix of all accesses
        for (int i = 0; i < 800; i++) begin
            int op;
            logic [7:0] d;
            op = $urandom_range(0, 9);
            d  = 8'($urandom);
            case (op)
                0:       access(1, 3'd0, d, "R4");
                1:       access(1, 3'd1, d, "R6");
                2:       access(1, 3'd2, d, "R2");
                3, 4:    access(1, 3'd3, d, "R8");
                5:       access(1, 3'd4, d, "R8");
                6, 7:    access(0, 3'd3, d, "R7");
                8:       access(0, 3'd4, d, "R7");
                default: access(0, 3'($urandom_range(0, 2)), d, "R7");
            endcase
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule